// File: doc/BRIEF.md
# Successive-approximation converter control and output port

This block is the digital front of a 16-bit successive-approximation converter. It turns a chip-select line and a read/convert line into conversion starts. It times each conversion with a cycle counter and holds the finished result in an output register. It presents that register on a parallel bus that is split into two 8-bit lanes. A test input word stands in for the analog core, and the block captures it in the last cycle of each conversion.

The two control lines are level-combined. A conversion begins once both have been low for a minimum qualified time, whichever of them fell last. While a conversion runs, the status line is low and further requests are refused. If the request is still asserted when the status line rises, a back-to-back conversion starts at once, and its result is flagged as untrustworthy. During a conversion the previous result can still be read for a limited window. After that the lanes carry no valid data until the new result lands. A byte-select input chooses which half of the word appears on each lane.

The bus is shown as data lanes plus an output-enable, with no internal three-state drivers. The chip-select, read/convert and byte-select inputs each pass through a two-flop synchronizer. Every duration is given in nanoseconds and converted to clock cycles from a clock-frequency parameter. The defaults are 125 MHz, 8000 ns conversion, 7000 ns read-back window and 40 ns minimum request.

Top module: `sar_ctrl_if`

## Requirements
- R1: A conversion starts only after `cs_n` and `rd_conv` have both been low together for at least PULSE_CYC consecutive synchronized cycles (5 at defaults). It does not matter which line fell last. A shorter joint-low request starts nothing.
- R2: `busy_n` is low for exactly CONV_CYC cycles per conversion (1000 at defaults). In the cycle it rises, the output register already holds `core_word` as sampled in the final conversion cycle.
- R3: Requests made while `busy_n` is low neither restart nor lengthen the running conversion. A request that is released before the conversion ends starts nothing afterwards, and `result_ok` does not change during a conversion.
- R4: If the request is still held when `busy_n` rises, the next conversion starts one cycle later, and its result carries `result_ok` = 0. A conversion whose request was released before it started carries `result_ok` = 1.
- R5: `bus_oe` is 1 only when the synchronized `rd_conv` is 1 and the synchronized `cs_n` is 0, two clock edges after the pins. Whenever `bus_oe` is 0, both lanes are 0.
- R6: With `byte_sel` = 0, `lane_a` carries bits 15..8 and `lane_b` carries bits 7..0. With `byte_sel` = 1, the two lanes swap.
- R7: During a conversion, `bus_valid` stays 1 and the lanes show the previous result for the first HOLD_CYC cycles (875 at defaults). For the rest of the conversion, `bus_valid` is 0 and the lanes read 0.
- R8: Results pass through unchanged in two's complement form. The codes 0x7FFF (positive full scale), 0x0000, 0xFFFF (one step below zero) and 0x8000 (negative full scale) appear on the lanes exactly as captured.
- R9: After reset, `busy_n` = 1, `bus_oe` = 0, the lanes read 0, `result_ok` = 0, and an enabled bus shows 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Active-low chip select |
| rd_conv | input | 1 | High selects read, low requests a conversion |
| byte_sel | input | 1 | Lane swap select |
| core_word | input | 16 | Stand-in for the analog core result |
| busy_n | output | 1 | Low while a conversion runs |
| bus_oe | output | 1 | Lane output enable (high means the bus would be driven) |
| bus_valid | output | 1 | Lanes carry a trustworthy result |
| lane_a | output | 8 | First byte lane |
| lane_b | output | 8 | Second byte lane |
| result_ok | output | 1 | Held result came from a properly acquired conversion |

## Verification
The assertions assume that the control pins change away from the rising clock edge. They also assume that `core_word` is steady around the final cycle of each conversion. The bench drives every pin on the falling edge and changes `core_word` only while no conversion is about to finish. The pin-to-enable property ignores the first few cycles after reset, because the synchronizers still hold their reset values then. The lane-swap property is only checked while the held result is stable, and the stimulus toggles `byte_sel` only between conversions.

// File: rtl/sar_pkg.sv
package sar_pkg;
  // Convert a duration in ns into whole clock cycles, rounding up.
  function automatic int unsigned ns_to_cyc(input int unsigned clk_mhz,
                                            input int unsigned dur_ns);
    return (clk_mhz * dur_ns + 999) / 1000;
  endfunction
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int         W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/sar_cmd_qual.sv
module sar_cmd_qual #(
  parameter int PULSE_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic idle,
  output logic start,
  output logic fresh
);
  localparam int CW = $clog2(PULSE_CYC + 1);

  logic [CW-1:0] run_q, run_d;
  logic          rel_q, rel_d;

  always_comb begin
    run_d = run_q;
    if (!req)
      run_d = '0;
    else if (run_q != CW'(PULSE_CYC))
      run_d = run_q + 1'b1;

    start = idle && req && (run_q >= CW'(PULSE_CYC - 1));

    rel_d = rel_q;
    if (start)
      rel_d = 1'b0;
    else if (!req)
      rel_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      rel_q <= 1'b1;
    end else begin
      run_q <= run_d;
      rel_q <= rel_d;
    end
  end

  assign fresh = rel_q;
endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int W        = 16,
  parameter int CONV_CYC = 1000,
  parameter int HOLD_CYC = 875
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         fresh,
  input  logic [W-1:0] core_word,
  output logic         conv,
  output logic         prev_ok,
  output logic [W-1:0] result,
  output logic         result_ok
);
  localparam int TW = $clog2(CONV_CYC + 1);

  logic          conv_d;
  logic [TW-1:0] tick_q, tick_d;
  logic          acq_q, acq_d;
  logic          done;
  logic          res_en;

  always_comb begin
    done   = conv && (tick_q == TW'(CONV_CYC - 1));
    conv_d = conv;
    tick_d = tick_q;
    acq_d  = acq_q;
    res_en = 1'b0;
    if (start) begin
      conv_d = 1'b1;
      tick_d = '0;
      acq_d  = fresh;
    end else if (conv) begin
      if (done) begin
        conv_d = 1'b0;
        res_en = 1'b1;
      end else begin
        tick_d = tick_q + 1'b1;
      end
    end
    prev_ok = !conv || (tick_q < TW'(HOLD_CYC));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv   <= 1'b0;
      tick_q <= '0;
      acq_q  <= 1'b0;
    end else begin
      conv   <= conv_d;
      tick_q <= tick_d;
      acq_q  <= acq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result    <= '0;
      result_ok <= 1'b0;
    end else if (res_en) begin
      result    <= core_word;
      result_ok <= acq_q;
    end
  end
endmodule

// File: rtl/sar_ctrl_if.sv
module sar_ctrl_if #(
  parameter int unsigned CLK_MHZ  = 125,
  parameter int unsigned CONV_NS  = 8000,
  parameter int unsigned HOLD_NS  = 7000,
  parameter int unsigned PULSE_NS = 40,
  parameter int          W        = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_n,
  input  logic           rd_conv,
  input  logic           byte_sel,
  input  logic [W-1:0]   core_word,
  output logic           busy_n,
  output logic           bus_oe,
  output logic           bus_valid,
  output logic [W/2-1:0] lane_a,
  output logic [W/2-1:0] lane_b,
  output logic           result_ok
);
  import sar_pkg::*;

  localparam int LANE      = W / 2;
  localparam int CONV_CYC  = int'(ns_to_cyc(CLK_MHZ, CONV_NS));
  localparam int HOLD_CYC  = int'(ns_to_cyc(CLK_MHZ, HOLD_NS));
  localparam int PULSE_CYC = int'(ns_to_cyc(CLK_MHZ, PULSE_NS));

  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic cs_s, rc_s, bs_s;
  sar_sync #(.W(3), .RST_VAL(3'b110)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     ({cs_n, rd_conv, byte_sel}),
    .q     ({cs_s, rc_s, bs_s})
  );

  logic req, start, fresh, conv, prev_ok;
  logic [W-1:0] result;

  assign req = !cs_s && !rc_s;

  sar_cmd_qual #(.PULSE_CYC(PULSE_CYC)) u_qual (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .req   (req),
    .idle  (!conv),
    .start (start),
    .fresh (fresh)
  );

  sar_seq #(.W(W), .CONV_CYC(CONV_CYC), .HOLD_CYC(HOLD_CYC)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (start),
    .fresh     (fresh),
    .core_word (core_word),
    .conv      (conv),
    .prev_ok   (prev_ok),
    .result    (result),
    .result_ok (result_ok)
  );

  assign busy_n    = !conv;
  assign bus_oe    = rc_s && !cs_s;
  assign bus_valid = prev_ok;

  logic [LANE-1:0] hi_half, lo_half;
  assign hi_half = result[W-1:LANE];
  assign lo_half = result[LANE-1:0];

  always_comb begin
    lane_a = '0;
    lane_b = '0;
    if (bus_oe && bus_valid) begin
      lane_a = bs_s ? lo_half : hi_half;
      lane_b = bs_s ? hi_half : lo_half;
    end
  end
endmodule

// File: rtl/sar_ctrl_if_chk.sv
module sar_ctrl_if_chk #(
  parameter int CONV_CYC = 1000,
  parameter int HOLD_CYC = 875,
  parameter int LANE     = 8
) (
  input logic            clk,
  input logic            rst_sync_n,
  input logic            cs_n,
  input logic            rd_conv,
  input logic            bs_s,
  input logic            busy_n,
  input logic            bus_oe,
  input logic            bus_valid,
  input logic [LANE-1:0] lane_a,
  input logic [LANE-1:0] lane_b,
  input logic            result_ok
);
  int low_cnt;
  int since;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      low_cnt <= 0;
      since   <= 0;
    end else begin
      low_cnt <= busy_n ? 0 : low_cnt + 1;
      if (since < 8) since <= since + 1;
    end
  end

  AST_CONV_LEN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(busy_n) |-> low_cnt == CONV_CYC); // R2

  AST_FLAG_HELD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!busy_n && !$past(busy_n)) |-> $stable(result_ok)); // R3

  AST_PIN_ENABLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (since >= 4) |-> (bus_oe == ($past(rd_conv, 2) && !$past(cs_n, 2)))); // R5

  AST_LANE_SWAP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_oe && $past(bus_oe) && bus_valid && $past(bus_valid) &&
     busy_n && $past(busy_n) && (bs_s != $past(bs_s)))
    |-> (lane_a == $past(lane_b) && lane_b == $past(lane_a))); // R6

  AST_STALE_WINDOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!busy_n && low_cnt >= HOLD_CYC) |-> !bus_valid); // R7

  AST_PREV_HELD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!busy_n && low_cnt < HOLD_CYC) |-> bus_valid); // R7
endmodule

bind sar_ctrl_if sar_ctrl_if_chk #(
  .CONV_CYC (CONV_CYC),
  .HOLD_CYC (HOLD_CYC),
  .LANE     (LANE)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .cs_n       (cs_n),
  .rd_conv    (rd_conv),
  .bs_s       (bs_s),
  .busy_n     (busy_n),
  .bus_oe     (bus_oe),
  .bus_valid  (bus_valid),
  .lane_a     (lane_a),
  .lane_b     (lane_b),
  .result_ok  (result_ok)
);

// File: tb/sar_ctrl_if_bench.sv
module sar_ctrl_if_bench;
  localparam int CONV = 1000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, rd_conv, byte_sel;
  logic [15:0] core_word;
  logic        busy_n, bus_oe, bus_valid, result_ok;
  logic [7:0]  lane_a, lane_b;

  always #4 clk = ~clk;

  sar_ctrl_if u_sar_ctrl_if (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .rd_conv   (rd_conv),
    .byte_sel  (byte_sel),
    .core_word (core_word),
    .busy_n    (busy_n),
    .bus_oe    (bus_oe),
    .bus_valid (bus_valid),
    .lane_a    (lane_a),
    .lane_b    (lane_b),
    .result_ok (result_ok)
  );

  typedef struct {
    logic [15:0] w;
    logic        ok;
    logic        chk;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  int   low_len = 0;
  bit   done = 0;
  bit   mon_on = 0;

  task automatic check(input bit good, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_busy(input logic lvl, input int maxc);
    for (int i = 0; i < maxc && busy_n !== lvl; i++) @(negedge clk);
  endtask

  task automatic push(input logic [15:0] w, input logic ok, input logic chk);
    exp_t e;
    e.w = w; e.ok = ok; e.chk = chk;
    q.push_back(e);
  endtask

  // Monitor: measures each busy period and scores the result it yields.
  always @(negedge clk) begin
    if (mon_on) begin
      if (!busy_n) low_len++;
      else if (low_len != 0) begin
        check(low_len == CONV, "R2", "busy length", low_len, CONV);
        if (q.size() == 0) begin
          check(1'b0, "R3", "unexpected conversion", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(result_ok === e.ok, "R4", "result_ok", result_ok, e.ok);
          if (e.chk)
            check(bus_oe === 1'b1 && {lane_a, lane_b} === e.w, "R8",
                  "result word", {lane_a, lane_b}, e.w);
        end
        low_len = 0;
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R2", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; rd_conv = 1'b1; byte_sel = 1'b0;
    core_word = 16'h0000;
    cyc(5);
    rst_n = 1'b1;
    cyc(6);
    mon_on = 1;
    // R9 reset state
    check(busy_n === 1'b1, "R9", "busy_n after reset", busy_n, 1);
    check(bus_oe === 1'b0, "R9", "bus_oe after reset", bus_oe, 0);
    check({lane_a, lane_b} === 16'h0, "R9", "lanes after reset", {lane_a, lane_b}, 0);
    check(result_ok === 1'b0, "R9", "result_ok after reset", result_ok, 0);
    cs_n = 1'b0;
    cyc(4);
    check(bus_oe === 1'b1, "R5", "enable with read", bus_oe, 1);
    check({lane_a, lane_b} === 16'h0, "R9", "reset word on bus", {lane_a, lane_b}, 0);

    // R1: request one cycle too short
    rd_conv = 1'b0;
    cyc(3);
    check(bus_oe === 1'b0, "R5", "off while converting line low", bus_oe, 0);
    cyc(1);
    rd_conv = 1'b1;
    cyc(20);
    check(busy_n === 1'b1, "R1", "short request ignored", busy_n, 1);

    // Conversion: positive full scale, with read-back window checks
    core_word = 16'h7FFF;
    push(16'h7FFF, 1'b1, 1'b1);
    rd_conv = 1'b0;
    cyc(5);
    rd_conv = 1'b1;
    wait_busy(1'b0, 20);
    check(busy_n === 1'b0, "R1", "minimum request accepted", busy_n, 0);
    cyc(100);
    check(bus_valid === 1'b1, "R7", "early window valid", bus_valid, 1);
    check({lane_a, lane_b} === 16'h0000, "R7", "previous word readable",
          {lane_a, lane_b}, 16'h0000);
    cyc(800);
    check(bus_valid === 1'b0, "R7", "late window invalid", bus_valid, 0);
    check({lane_a, lane_b} === 16'h0, "R7", "late window lanes", {lane_a, lane_b}, 0);
    wait_busy(1'b1, 300);
    cyc(3);

    // R6 byte swap
    byte_sel = 1'b1;
    cyc(4);
    check(lane_a === 8'hFF && lane_b === 8'h7F, "R6", "swapped lanes",
          {lane_a, lane_b}, 16'hFF7F);
    byte_sel = 1'b0;
    cyc(4);
    check(lane_a === 8'h7F && lane_b === 8'hFF, "R6", "straight lanes",
          {lane_a, lane_b}, 16'h7FFF);

    // R8 codes: zero and one step below zero
    core_word = 16'h0000;
    push(16'h0000, 1'b1, 1'b1);
    rd_conv = 1'b0; cyc(6); rd_conv = 1'b1;
    wait_busy(1'b0, 20); wait_busy(1'b1, 1100); cyc(3);
    core_word = 16'hFFFF;
    push(16'hFFFF, 1'b1, 1'b1);
    rd_conv = 1'b0; cyc(6); rd_conv = 1'b1;
    wait_busy(1'b0, 20); wait_busy(1'b1, 1100); cyc(3);

    // R1: chip select falls last and triggers; negative full scale
    core_word = 16'h8000;
    push(16'h8000, 1'b1, 1'b1);
    cs_n = 1'b1; cyc(1);
    rd_conv = 1'b0; cyc(8);
    check(busy_n === 1'b1, "R1", "no start with chip select high", busy_n, 1);
    cs_n = 1'b0; cyc(5);
    rd_conv = 1'b1;
    wait_busy(1'b0, 20);
    check(busy_n === 1'b0, "R1", "start on chip select", busy_n, 0);
    wait_busy(1'b1, 1100); cyc(3);

    // R3 lockout
    core_word = 16'h1234;
    push(16'h1234, 1'b1, 1'b1);
    rd_conv = 1'b0; cyc(6); rd_conv = 1'b1;
    wait_busy(1'b0, 20);
    cyc(50);
    rd_conv = 1'b0; cyc(20); rd_conv = 1'b1;
    wait_busy(1'b1, 1100);
    cyc(40);
    check(busy_n === 1'b1, "R3", "no start after lockout", busy_n, 1);
    check(q.size() == 0, "R3", "no extra conversion", q.size(), 0);

    // R4 back-to-back restart
    core_word = 16'hAAAA;
    push(16'hAAAA, 1'b1, 1'b0);
    push(16'h5555, 1'b0, 1'b1);
    rd_conv = 1'b0;
    wait_busy(1'b0, 20);
    wait_busy(1'b1, 1100);
    core_word = 16'h5555;
    cyc(1);
    check(busy_n === 1'b0, "R4", "immediate restart", busy_n, 0);
    cyc(10);
    rd_conv = 1'b1;
    wait_busy(1'b1, 1100); cyc(3);

    core_word = 16'h0F0F;
    push(16'h0F0F, 1'b1, 1'b1);
    rd_conv = 1'b0; cyc(6); rd_conv = 1'b1;
    wait_busy(1'b0, 20); wait_busy(1'b1, 1100); cyc(3);

    // R5 deselect
    cs_n = 1'b1;
    cyc(4);
    check(bus_oe === 1'b0, "R5", "off with chip select high", bus_oe, 0);
    check({lane_a, lane_b} === 16'h0, "R5", "lanes zero when off", {lane_a, lane_b}, 0);
    check(q.size() == 0, "R2", "all results seen", q.size(), 0);
    finish_run();
  end
endmodule